// File: doc/BRIEF.md
# Coprocessor Claim Arbiter

This block lets a CPU core share one instruction path with up to sixteen coprocessor slots without giving any slot its own select line. When the core sends a coprocessor instruction, it pulses a strobe and puts the instruction on a shared bus. Every populated slot compares the 4-bit identifier in bits [11:8] of that instruction with its own number. The slot that matches answers with an acknowledge. Identifier 15 belongs to the memory-management slot.

On the core side, a controller stalls the pipeline from the cycle after the strobe. It waits at most two cycles for an acknowledge. If a slot holds busy after acknowledging, the controller keeps stalling and signals completion one cycle after busy drops. If no acknowledge arrives inside the window, the instruction is treated as unimplemented and a single-cycle fault pulse is produced. Because of this, a slot that is absent from the build needs no tie-off: it shows up only as a silent slot.

A parameter mask sets which slots are built. A second parameter gives each slot's identifier, so a build that duplicates an identifier is still legal. The slot datapaths are stubs whose timing is taken from low instruction bits:

- bits [5:4] hold the acknowledge delay minus one, giving 1 to 4 cycles;
- bits [3:0] hold the number of cycles busy stays high, starting in the acknowledge cycle.

Top module: `coproClaimArb`

## Requirements
- R1: After reset, stall, opDone, undefFault and busConflict are all low.
- R2: Only a populated slot whose identifier equals instruction bits [11:8] acknowledges a strobed instruction. With the stub, its acknowledge appears bits[5:4]+1 cycles after the strobe cycle.
- R3: If the acknowledge comes in cycle 1 or 2 after the strobe and the stub busy length (bits [3:0]) is zero, opDone pulses for one cycle in the cycle after the acknowledge.
- R4: If no acknowledge arrives in cycles 1 and 2 after the strobe, undefFault is high for exactly cycle 3 after the strobe, and opDone stays low.
- R5: An identifier whose slot is clear in the presence mask produces the R4 fault.
- R6: An acknowledge that arrives in cycle 3 or later after the strobe is ignored: opDone does not pulse for that instruction.
- R7: With a busy length L > 0 and an acknowledge in cycle d, opDone pulses in cycle d+L+1, which is the cycle after busy falls.
- R8: stall is high from cycle 1 after the strobe up to the cycle before opDone or undefFault, and low in that cycle.
- R9: If two or more slots acknowledge in the same cycle inside the window, busConflict pulses in the following cycle.
- R10: The default build populates slot 15 (memory management), and identifier 15 completes like any other present slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Coprocessor-instruction strobe, one cycle |
| issueInstr | input | 32 | Broadcast instruction; identifier in bits [11:8] |
| stall | output | 1 | Core pipeline hold while an instruction is outstanding |
| opDone | output | 1 | One-cycle completion pulse |
| undefFault | output | 1 | One-cycle unimplemented-instruction fault |
| busConflict | output | 1 | One-cycle flag for simultaneous acknowledges |

## Verification
The assertions assume that the core never strobes a new instruction while stall is high. They also assume that a slot still busy or pending from an earlier instruction is not reclaimed before it has gone quiet, because a late acknowledge from an old instruction must not fall into the window of a new one. The stimulus issues one instruction at a time and then waits twelve cycles. That is longer than the slowest stub acknowledge plus busy run, so every slot is idle before the next strobe. A second build with a duplicated identifier is run on the same stimulus so that the conflict path is reached while the properties still hold.

// File: rtl/coproPkg.sv
package coproPkg;
  typedef struct packed {
    logic ackAny;
    logic ackMulti;
    logic busyAny;
  } slotStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUSY = 2'd2
  } ctrlState_t;
endpackage

// File: rtl/coproSlot.sv
module coproSlot #(
  parameter int INSTR_W = 32,
  parameter int ID_W    = 4,
  parameter int ID_LSB  = 8,
  parameter int LAT_LSB = 4,
  parameter int LAT_W   = 2,
  parameter int LEN_W   = 4,
  parameter logic [ID_W-1:0] MY_ID = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [INSTR_W-1:0] issueInstr,
  output logic               ack,
  output logic               busy
);
  localparam int PEND_W = LAT_W + 1;

  logic [PEND_W-1:0] pendCnt;
  logic [LEN_W-1:0]  busyLen;
  logic [LEN_W-1:0]  busyCnt;
  logic              claim;
  logic              unusedInstrParity;

  assign unusedInstrParity = ^issueInstr;
  assign claim = issueValid && (issueInstr[ID_LSB +: ID_W] == MY_ID);
  assign ack   = (pendCnt == PEND_W'(1));
  assign busy  = (ack && (busyLen != '0)) || (busyCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCnt <= '0;
      busyLen <= '0;
      busyCnt <= '0;
    end else begin
      if (claim) begin
        pendCnt <= {1'b0, issueInstr[LAT_LSB +: LAT_W]} + PEND_W'(1);
        busyLen <= issueInstr[LEN_W-1:0];
      end else if (pendCnt != '0) begin
        pendCnt <= pendCnt - PEND_W'(1);
      end
      if (ack && (busyLen != '0)) begin
        busyCnt <= busyLen - LEN_W'(1);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/coproDatapath.sv
module coproDatapath
  import coproPkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int INSTR_W   = 32,
  parameter int ID_W      = 4,
  parameter int ID_LSB    = 8,
  parameter logic [NUM_SLOTS-1:0]      PRESENT_MASK = 16'h8035,
  parameter logic [NUM_SLOTS*ID_W-1:0] SLOT_IDS     = 64'hFEDC_BA98_7654_3210
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [INSTR_W-1:0] issueInstr,
  output slotStatus_t        slotStatus
);
  logic [NUM_SLOTS-1:0] ackVec;
  logic [NUM_SLOTS-1:0] busyVec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (PRESENT_MASK[i]) begin : g_present
      coproSlot #(
        .INSTR_W(INSTR_W),
        .ID_W   (ID_W),
        .ID_LSB (ID_LSB),
        .MY_ID  (SLOT_IDS[i*ID_W +: ID_W])
      ) slot_i (
        .clk       (clk),
        .rstN      (rstN),
        .issueValid(issueValid),
        .issueInstr(issueInstr),
        .ack       (ackVec[i]),
        .busy      (busyVec[i])
      );
    end else begin : g_absent
      assign ackVec[i]  = 1'b0;
      assign busyVec[i] = 1'b0;
    end
  end

  assign slotStatus.ackAny   = |ackVec;
  assign slotStatus.ackMulti = (ackVec & (ackVec - NUM_SLOTS'(1))) != '0;
  assign slotStatus.busyAny  = |busyVec;
endmodule

// File: rtl/coproCtrl.sv
module coproCtrl
  import coproPkg::*;
#(
  parameter int ACK_WINDOW = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        issueValid,
  input  slotStatus_t slotStatus,
  output logic        stall,
  output logic        opDone,
  output logic        undefFault,
  output logic        busConflict
);
  localparam int CNT_W = $clog2(ACK_WINDOW + 1);

  ctrlState_t       state;
  logic [CNT_W-1:0] waitCnt;

  assign stall = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      waitCnt     <= '0;
      opDone      <= 1'b0;
      undefFault  <= 1'b0;
      busConflict <= 1'b0;
    end else begin
      opDone      <= 1'b0;
      undefFault  <= 1'b0;
      busConflict <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (issueValid) begin
            state   <= ST_WAIT;
            waitCnt <= CNT_W'(1);
          end
        end
        ST_WAIT: begin
          if (slotStatus.ackAny) begin
            busConflict <= slotStatus.ackMulti;
            if (slotStatus.busyAny) begin
              state <= ST_BUSY;
            end else begin
              opDone <= 1'b1;
              state  <= ST_IDLE;
            end
          end else if (waitCnt == CNT_W'(ACK_WINDOW)) begin
            undefFault <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt + CNT_W'(1);
          end
        end
        ST_BUSY: begin
          if (!slotStatus.busyAny) begin
            opDone <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coproClaimArb.sv
module coproClaimArb
  import coproPkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int INSTR_W    = 32,
  parameter int ID_W       = 4,
  parameter int ID_LSB     = 8,
  parameter int ACK_WINDOW = 2,
  parameter logic [NUM_SLOTS-1:0]      PRESENT_MASK = 16'h8035,
  parameter logic [NUM_SLOTS*ID_W-1:0] SLOT_IDS     = 64'hFEDC_BA98_7654_3210
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [INSTR_W-1:0] issueInstr,
  output logic               stall,
  output logic               opDone,
  output logic               undefFault,
  output logic               busConflict
);
  slotStatus_t slotStatus;

  coproDatapath #(
    .NUM_SLOTS   (NUM_SLOTS),
    .INSTR_W     (INSTR_W),
    .ID_W        (ID_W),
    .ID_LSB      (ID_LSB),
    .PRESENT_MASK(PRESENT_MASK),
    .SLOT_IDS    (SLOT_IDS)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .issueInstr(issueInstr),
    .slotStatus(slotStatus)
  );

  coproCtrl #(
    .ACK_WINDOW(ACK_WINDOW)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .slotStatus (slotStatus),
    .stall      (stall),
    .opDone     (opDone),
    .undefFault (undefFault),
    .busConflict(busConflict)
  );
endmodule

// File: rtl/coproClaimChk.sv
module coproClaimChk
  import coproPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        issueValid,
  input logic        stall,
  input logic        opDone,
  input logic        undefFault,
  input logic        busConflict,
  input slotStatus_t slotStatus
);
  assert_stall_on_issue_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !stall) |=> stall);

  assert_done_after_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> ($past(stall) && !stall));

  assert_fault_after_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    undefFault |-> ($past(stall) && $past(stall, 2) && !$past(slotStatus.ackAny)));

  assert_fault_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    undefFault |=> !undefFault);

  assert_fault_excludes_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(undefFault && opDone));

  assert_busy_holds_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stall && slotStatus.ackAny && slotStatus.busyAny) |=> (stall && !opDone));

  assert_conflict_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    busConflict |-> ($past(slotStatus.ackMulti) && $past(stall)));
endmodule

bind coproClaimArb coproClaimChk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .stall      (stall),
  .opDone     (opDone),
  .undefFault (undefFault),
  .busConflict(busConflict),
  .slotStatus (slotStatus)
);

// File: tb/coproClaimArb_tb_top.sv
`timescale 1ns/1ps
module coproClaimArb_tb_top;
  localparam logic [15:0] MASK_A = 16'h8035;
  localparam logic [63:0] IDS_A  = 64'hFEDC_BA98_7654_3210;
  localparam logic [15:0] MASK_B = 16'h000C;
  localparam logic [63:0] IDS_B  = 64'hFEDC_BA98_7654_2210;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] issueInstr = '0;
  logic        stallA, doneA, faultA, confA;
  logic        stallB, doneB, faultB, confB;
  int          testCount = 0;
  int          failCount = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  coproClaimArb dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueInstr(issueInstr),
    .stall(stallA), .opDone(doneA), .undefFault(faultA), .busConflict(confA)
  );

  coproClaimArb #(.PRESENT_MASK(MASK_B), .SLOT_IDS(IDS_B)) dutDup_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueInstr(issueInstr),
    .stall(stallB), .opDone(doneB), .undefFault(faultB), .busConflict(confB)
  );

  function automatic int claimCount(logic [15:0] mask, logic [63:0] ids, int id);
    int n = 0;
    for (int s = 0; s < 16; s++)
      if (mask[s] && (int'(ids[s*4 +: 4]) == id)) n++;
    return n;
  endfunction

  // expected {stall, opDone, undefFault, busConflict} in cycle k after the strobe
  function automatic logic [3:0] expectVec(int cnt, int k, int d, int len);
    logic [3:0] v = '0;
    if (cnt > 0 && d <= 2) begin
      v[3] = (k < d + len + 1);
      v[2] = (k == d + len + 1);
      v[0] = (cnt > 1) && (k == d + 1);
    end else begin
      v[3] = (k < 3);
      v[1] = (k == 3);
    end
    return v;
  endfunction

  function automatic string tagFor(int bitIdx, int cnt, int d, int len, int id);
    case (bitIdx)
      3: return "R8";
      2: return (id == 15) ? "R10" : ((cnt > 0 && d > 2) ? "R6" : ((len > 0) ? "R7" : "R3"));
      1: return (cnt == 0) ? "R5" : ((d > 2) ? "R6" : "R2");
      default: return "R9";
    endcase
  endfunction

  task automatic runOne(int id, int d, int len);
    int cntA = claimCount(MASK_A, IDS_A, id);
    int cntB = claimCount(MASK_B, IDS_B, id);
    bit badA = 1'b0;
    bit badB = 1'b0;
    @(negedge clk);
    issueValid = 1'b1;
    issueInstr = (32'(id) << 8) | (32'(d - 1) << 4) | 32'(len);
    @(negedge clk);
    issueValid = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      logic [3:0] eA = expectVec(cntA, k, d, len);
      logic [3:0] eB = expectVec(cntB, k, d, len);
      logic [3:0] oA = {stallA, doneA, faultA, confA};
      logic [3:0] oB = {stallB, doneB, faultB, confB};
      for (int b = 0; b < 4; b++) begin
        if (oA[b] !== eA[b]) begin
          badA = 1'b1;
          $display("FAIL %s main id=%0d d=%0d len=%0d cycle=%0d sig=%0d actual=%b expected=%b",
                   tagFor(b, cntA, d, len, id), id, d, len, k, b, oA[b], eA[b]);
        end
        if (oB[b] !== eB[b]) begin
          badB = 1'b1;
          $display("FAIL %s dup id=%0d d=%0d len=%0d cycle=%0d sig=%0d actual=%b expected=%b",
                   tagFor(b, cntB, d, len, id), id, d, len, k, b, oB[b], eB[b]);
        end
      end
      @(negedge clk);
    end
    testCount += 2;
    if (badA) failCount++;
    if (badB) failCount++;
  endtask

  initial begin
    int lens[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    testCount++;
    if ({stallA, doneA, faultA, confA, stallB, doneB, faultB, confB} !== 8'h00) begin
      failCount++;
      $display("FAIL R1 reset outputs actual=%b expected=00000000",
               {stallA, doneA, faultA, confA, stallB, doneB, faultB, confB});
    end
    // R2..R10: sweep every identifier, acknowledge delay and busy length
    for (int id = 0; id < 16; id++)
      for (int d = 1; d <= 4; d++)
        for (int li = 0; li < 3; li++)
          runOne(id, d, lens[li]);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule